// File: doc/BRIEF.md
# TDM Connection Memory Output Controller

This block forms the output half of a time-slot interchange switch with two output ports: a local port and a backplane port. Each port has its own routing table of 4096 sixteen-bit words, and a host processor writes and reads these tables. A slot sequencer walks every output stream and channel of a frame, one step per slot strobe. For each slot it fetches that slot's word from both tables. Each port then acts on its own word. It either requests one byte from one of two external source data memories, or it takes a message byte stored in the word. It also drives or silences the output for that slot.

The source data memories lie outside the block. They are reached through one read port per output port: an enable, a flag that picks the local or the backplane data memory, a 13-bit address, and an 8-bit data input that must answer in the same cycle. A slot strobe and the host share each routing table. The slot fetch always wins, and the host is held off with a ready flag.

Top module: `tsi_out_ctrl`

## Requirements
- R1: A host access with `host_sel` = 3'b000 reaches the local routing table and one with 3'b001 reaches the backplane table, each at index `host_addr` (0 to 4095). A read returns the stored 16-bit word on `host_rdata` one cycle after it is accepted (`host_req` and `host_ready` both high).
- R2: A host access with any other `host_sel` code is accepted at once, even in a strobe cycle. It changes neither table, and a read made with such a code returns 0.
- R3: The slot index used by a strobe is 0 when `frame_sync` is high in that cycle. Otherwise it is one more than the previous strobe's index, wrapping from 4095 to 0. The index is made of a 5-bit output stream (upper bits) and a 7-bit output channel, and it is reported on `out_slot` with the result.
- R4: Each `slot_tick` yields exactly one `out_valid` pulse, and it arrives two clock cycles after the strobe.
- R5: On the local port, word bit 15 = 1 takes source data from the local data memory (`loc_rd_local` = 1), and bit 15 = 0 takes it from the backplane data memory.
- R6: On the backplane port, bit 15 has the opposite polarity: 1 takes backplane data and 0 takes local data.
- R7: When word bit 14 = 0 (connection mode), the port issues a source read whose address is word bits 12:0: source stream in bits 12:7 and source channel in bits 6:0. The returned byte becomes the slot's output.
- R8: When word bit 14 = 1 (message mode), the slot's output byte is word bits 7:0. Bits 12:8 and the source data input have no effect, and no source read is issued.
- R9: Word bit 13 is the slot's output enable. `*_oe` takes its value, and when it is 0 the output byte is 0, in either mode.
- R10: In a cycle with `slot_tick` high, `host_ready` is low for codes 000 and 001. A stalled access completes in the first cycle without a strobe.
- R11: Synchronous active-high reset clears `out_valid`, both output enables, both output bytes and `host_rdata`, and it sets the next slot index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_tick | input | 1 | Start one slot this cycle |
| frame_sync | input | 1 | Restart the slot index at 0 |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_sel | input | 3 | Table select code |
| host_addr | input | 12 | Table index |
| host_wdata | input | 16 | Host write word |
| host_ready | output | 1 | Host access accepted this cycle |
| host_rdata | output | 16 | Host read word |
| loc_rd_en | output | 1 | Local port source read enable |
| loc_rd_local | output | 1 | Local port reads local (1) or backplane (0) data |
| loc_rd_addr | output | 13 | Local port source address |
| loc_rd_data | input | 8 | Local port source byte |
| loc_dout | output | 8 | Local port slot byte |
| loc_oe | output | 1 | Local port output enable |
| bp_rd_en | output | 1 | Backplane port source read enable |
| bp_rd_local | output | 1 | Backplane port reads local (1) or backplane (0) data |
| bp_rd_addr | output | 13 | Backplane port source address |
| bp_rd_data | input | 8 | Backplane port source byte |
| bp_dout | output | 8 | Backplane port slot byte |
| bp_oe | output | 1 | Backplane port output enable |
| out_valid | output | 1 | Slot result present |
| out_slot | output | 12 | Index of the slot result |

## Verification
Both tables are first filled with random words. A few directed entries are then placed so that every pairing of source bit, mode bit and enable bit shows up on each port. This separates a polarity mix-up between the ports from a mode or enable fault. The source data model hashes both the address and the selected memory, so a wrong address or a wrong memory choice gives a wrong byte. Message slots are fed a fixed junk byte to show they ignore the source. Strobes come back to back over a full frame wrap, then at random with random frame pulses. The host also hammers the tables during strobes, which tells the fetch priority apart from a lost or misplaced write.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int WORD_W     = 16;
    localparam int SRC_ADDR_W = 13;
    localparam int BYTE_W     = 8;
    localparam int SEL_W      = 3;

    localparam logic [SEL_W-1:0] SEL_LOCAL = 3'b000;
    localparam logic [SEL_W-1:0] SEL_BACK  = 3'b001;

    // Routing word layout; the bit positions are behaviour.
    typedef struct packed {
        logic                  src_hi;   // source choice, port dependent polarity
        logic                  msg;      // 1: stored byte, 0: switched data
        logic                  drive;    // per-slot output enable
        logic [SRC_ADDR_W-1:0] payload;  // source address or message byte
    } conn_word_t;

    typedef struct packed {
        logic                  rd_en;
        logic                  rd_local;
        logic [SRC_ADDR_W-1:0] rd_addr;
    } src_req_t;

    function automatic logic want_local(input logic src_hi, input logic bp_port);
        return src_hi ^ bp_port;
    endfunction

    function automatic logic [BYTE_W-1:0] slot_byte(input conn_word_t w,
                                                    input logic [BYTE_W-1:0] sw);
        if (!w.drive)
            return '0;
        else if (w.msg)
            return w.payload[BYTE_W-1:0];
        else
            return sw;
    endfunction

endpackage

// File: rtl/tsi_slot_seq.sv
module tsi_slot_seq #(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_tick,
    input  logic             frame_sync,
    output logic [IDX_W-1:0] cur_idx
);

    logic [IDX_W-1:0] cnt_q;

    assign cur_idx = frame_sync ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (slot_tick)
            cnt_q <= cur_idx + IDX_W'(1);
        else if (frame_sync)
            cnt_q <= '0;
    end

endmodule

// File: rtl/tsi_route_mem.sv
module tsi_route_mem
    import tsi_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic              clk,
    input  logic              seq_rd,
    input  logic [IDX_W-1:0]  seq_idx,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] seq_word,
    output logic [WORD_W-1:0] host_rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Single access per cycle; the slot fetch takes precedence.
    always_ff @(posedge clk) begin
        if (seq_rd) begin
            seq_word <= mem[seq_idx];
        end else if (host_en) begin
            if (host_we)
                mem[host_idx] <= host_wdata;
            else
                host_rdata <= mem[host_idx];
        end
    end

endmodule

// File: rtl/tsi_port_pipe.sv
module tsi_port_pipe
    import tsi_pkg::*;
#(
    parameter bit BP_PORT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s1_valid,
    input  conn_word_t        s1_word,
    input  logic [BYTE_W-1:0] src_data,
    output src_req_t          req,
    output logic [BYTE_W-1:0] dout,
    output logic              oe
);

    always_comb begin
        req.rd_en    = s1_valid & ~s1_word.msg;
        req.rd_local = want_local(s1_word.src_hi, BP_PORT);
        req.rd_addr  = s1_word.payload;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            oe   <= 1'b0;
        end else if (s1_valid) begin
            dout <= slot_byte(s1_word, src_data);
            oe   <= s1_word.drive;
        end
    end

endmodule

// File: rtl/tsi_out_ctrl.sv
module tsi_out_ctrl
    import tsi_pkg::*;
#(
    parameter  int OSTR_W = 5,
    parameter  int OCH_W  = 7,
    localparam int IDX_W  = OSTR_W + OCH_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  slot_tick,
    input  logic                  frame_sync,
    input  logic                  host_req,
    input  logic                  host_we,
    input  logic [SEL_W-1:0]      host_sel,
    input  logic [IDX_W-1:0]      host_addr,
    input  logic [WORD_W-1:0]     host_wdata,
    output logic                  host_ready,
    output logic [WORD_W-1:0]     host_rdata,
    output logic                  loc_rd_en,
    output logic                  loc_rd_local,
    output logic [SRC_ADDR_W-1:0] loc_rd_addr,
    input  logic [BYTE_W-1:0]     loc_rd_data,
    output logic [BYTE_W-1:0]     loc_dout,
    output logic                  loc_oe,
    output logic                  bp_rd_en,
    output logic                  bp_rd_local,
    output logic [SRC_ADDR_W-1:0] bp_rd_addr,
    input  logic [BYTE_W-1:0]     bp_rd_data,
    output logic [BYTE_W-1:0]     bp_dout,
    output logic                  bp_oe,
    output logic                  out_valid,
    output logic [IDX_W-1:0]      out_slot
);

    localparam int NPORT = 2;

    logic [IDX_W-1:0] cur_idx;

    tsi_slot_seq #(.IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .slot_tick  (slot_tick),
        .frame_sync (frame_sync),
        .cur_idx    (cur_idx)
    );

    // Host arbitration: table codes wait for a cycle without a strobe.
    logic [NPORT-1:0] sel_hit;
    logic             host_go;

    assign sel_hit[0]  = (host_sel == SEL_LOCAL);
    assign sel_hit[1]  = (host_sel == SEL_BACK);
    assign host_ready  = host_req & ~(slot_tick & (|sel_hit));
    assign host_go     = host_req & host_ready;

    // Stage 1 bookkeeping of the slot being fetched.
    logic             s1_valid;
    logic [IDX_W-1:0] s1_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_slot  <= '0;
        end else begin
            s1_valid <= slot_tick;
            if (slot_tick)
                s1_slot <= cur_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_slot  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid)
                out_slot <= s1_slot;
        end
    end

    logic [WORD_W-1:0] mem_word [NPORT];
    logic [WORD_W-1:0] mem_hrd  [NPORT];
    src_req_t          req      [NPORT];
    logic [BYTE_W-1:0] src_data [NPORT];
    logic [BYTE_W-1:0] dout     [NPORT];
    logic              oe       [NPORT];

    assign src_data[0] = loc_rd_data;
    assign src_data[1] = bp_rd_data;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        tsi_route_mem #(.IDX_W(IDX_W)) u_mem (
            .clk        (clk),
            .seq_rd     (slot_tick),
            .seq_idx    (cur_idx),
            .host_en    (host_go & sel_hit[p]),
            .host_we    (host_we),
            .host_idx   (host_addr),
            .host_wdata (host_wdata),
            .seq_word   (mem_word[p]),
            .host_rdata (mem_hrd[p])
        );

        tsi_port_pipe #(.BP_PORT(p == 1)) u_pipe (
            .clk      (clk),
            .rst      (rst),
            .s1_valid (s1_valid),
            .s1_word  (conn_word_t'(mem_word[p])),
            .src_data (src_data[p]),
            .req      (req[p]),
            .dout     (dout[p]),
            .oe       (oe[p])
        );
    end

    assign loc_rd_en    = req[0].rd_en;
    assign loc_rd_local = req[0].rd_local;
    assign loc_rd_addr  = req[0].rd_addr;
    assign loc_dout     = dout[0];
    assign loc_oe       = oe[0];
    assign bp_rd_en     = req[1].rd_en;
    assign bp_rd_local  = req[1].rd_local;
    assign bp_rd_addr   = req[1].rd_addr;
    assign bp_dout      = dout[1];
    assign bp_oe        = oe[1];

    // Host read return: the code of the last accepted read picks the source.
    logic [SEL_W-1:0] pend_sel;

    always_ff @(posedge clk) begin
        if (rst)
            pend_sel <= '1;
        else if (host_go && !host_we)
            pend_sel <= host_sel;
    end

    always_comb begin
        case (pend_sel)
            SEL_LOCAL: host_rdata = mem_hrd[0];
            SEL_BACK:  host_rdata = mem_hrd[1];
            default:   host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tsi_out_ctrl_chk.sv
module tsi_out_ctrl_chk #(
    parameter int IDX_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             slot_tick,
    input logic             frame_sync,
    input logic             host_req,
    input logic [2:0]       host_sel,
    input logic             host_ready,
    input logic             loc_rd_en,
    input logic             bp_rd_en,
    input logic [7:0]       loc_dout,
    input logic             loc_oe,
    input logic [7:0]       bp_dout,
    input logic             bp_oe,
    input logic             out_valid,
    input logic [IDX_W-1:0] out_slot
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    AST_HOST_HELD: assert property (@(posedge clk) disable iff (rst)
        (slot_tick && host_req && host_sel <= 3'd1) |-> !host_ready); // R10

    AST_BADSEL_FREE: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_sel > 3'd1) |-> host_ready); // R2

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_valid == $past(slot_tick, 2))); // R4

    AST_FRAME_ZERO: assert property (@(posedge clk) disable iff (rst)
        (slot_tick && frame_sync) |=> ##1 (out_valid && out_slot == '0)); // R3

    AST_SRC_READ_SLOT: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && (loc_rd_en || bp_rd_en)) |-> $past(slot_tick)); // R7

    AST_QUIET_LOC: assert property (@(posedge clk) disable iff (rst)
        !loc_oe |-> (loc_dout == 8'd0)); // R9

    AST_QUIET_BP: assert property (@(posedge clk) disable iff (rst)
        !bp_oe |-> (bp_dout == 8'd0)); // R9

endmodule

bind tsi_out_ctrl tsi_out_ctrl_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/tsi_out_ctrl_bench.sv
module tsi_out_ctrl_bench;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NSLOT      = 4096;
    localparam int  CYC_LIMIT  = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slot_tick = 1'b0, frame_sync = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [2:0]  host_sel = 3'd0;
    logic [11:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ready;
    logic [15:0] host_rdata;
    logic        loc_rd_en, loc_rd_local, bp_rd_en, bp_rd_local;
    logic [12:0] loc_rd_addr, bp_rd_addr;
    logic [7:0]  loc_rd_data, bp_rd_data, loc_dout, bp_dout;
    logic        loc_oe, bp_oe, out_valid;
    logic [11:0] out_slot;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tsi_out_ctrl u_tsi_out_ctrl (.*);

    // Source data model: depends on address and on which memory is chosen.
    function automatic logic [7:0] srcdat(input logic is_local, input logic [12:0] a);
        return (a[7:0] * 8'd29) ^ {3'b0, a[12:8]} ^ (is_local ? 8'h6B : 8'hB4);
    endfunction

    always_comb loc_rd_data = loc_rd_en ? srcdat(loc_rd_local, loc_rd_addr) : 8'hEE;
    always_comb bp_rd_data  = bp_rd_en  ? srcdat(bp_rd_local,  bp_rd_addr)  : 8'hEE;

    function automatic logic [7:0] exp_byte(input int p, input logic [15:0] w);
        logic use_local;
        use_local = (p == 0) ? w[15] : !w[15];
        if (!w[13])      return 8'h00;
        else if (w[14])  return w[7:0];
        else             return srcdat(use_local, w[12:0]);
    endfunction

    function automatic string tag_of(input int p, input logic [15:0] w);
        if (!w[13])     return "R9";
        else if (w[14]) return "R8";
        else            return (p == 0) ? "R5,R7" : "R6,R7";
    endfunction

    typedef struct {
        int          cyc;
        logic [11:0] slot;
        logic [15:0] lw;
        logic [15:0] bw;
    } exp_t;

    exp_t        q[$];
    logic [15:0] sh_loc [NSLOT];
    logic [15:0] sh_bp  [NSLOT];
    int          checks = 0, errors = 0, cycle = 0;
    int          exp_idx = 0, tick_mode = 0;
    bit          force_fp = 0, rand_fp = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic monitor();
        exp_t e;
        if (out_valid) begin
            if (q.size() == 0) begin
                chk("R4 unexpected out_valid", 1, 0);
            end else begin
                e = q.pop_front();
                chk("R4 latency", cycle, e.cyc + 2);
                chk("R3 slot index", 32'(out_slot), 32'(e.slot));
                chk({tag_of(0, e.lw), " local byte"}, 32'(loc_dout), 32'(exp_byte(0, e.lw)));
                chk({tag_of(0, e.lw), " local oe"}, 32'(loc_oe), 32'(e.lw[13]));
                chk({tag_of(1, e.bw), " backplane byte"}, 32'(bp_dout), 32'(exp_byte(1, e.bw)));
                chk({tag_of(1, e.bw), " backplane oe"}, 32'(bp_oe), 32'(e.bw[13]));
            end
        end else if (q.size() > 0 && q[0].cyc + 2 <= cycle) begin
            chk("R4 missing out_valid", 0, 1);
            void'(q.pop_front());
        end
    endtask

    task automatic step();
        bit   t, f;
        exp_t e;
        int   s;
        @(negedge clk);
        cycle++;
        if (cycle > CYC_LIMIT) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycle, CYC_LIMIT);
            finish_up();
        end
        monitor();
        t = (tick_mode == 1) || (tick_mode == 2 && ($urandom % 2) == 0);
        f = force_fp || (rand_fp && ($urandom % 300) == 0);
        force_fp = 0;
        if (t) begin
            s = f ? 0 : exp_idx;
            exp_idx = (s + 1) % NSLOT;
            e.cyc = cycle; e.slot = 12'(s); e.lw = sh_loc[s]; e.bw = sh_bp[s];
            q.push_back(e);
        end else if (f) begin
            exp_idx = 0;
        end
        slot_tick  = t;
        frame_sync = f;
    endtask

    task automatic host_op(input bit we, input logic [2:0] sel, input int addr,
                           input logic [15:0] wd, input string tag, output int stalls);
        stalls = 0;
        host_req = 1'b1; host_we = we; host_sel = sel;
        host_addr = 12'(addr); host_wdata = wd;
        #1;
        while (!host_ready) begin
            stalls++;
            if (stalls > 1000) begin
                chk({tag, " host never accepted"}, 0, 1);
                finish_up();
            end
            step();
            #1;
        end
        if (we && sel == 3'd0) sh_loc[addr] = wd;
        if (we && sel == 3'd1) sh_bp[addr]  = wd;
        step();
        host_req = 1'b0; host_we = 1'b0;
        if (!we)
            chk({tag, " host read word"}, 32'(host_rdata),
                32'(sel == 3'd0 ? sh_loc[addr] : sel == 3'd1 ? sh_bp[addr] : 16'h0));
    endtask

    task automatic put(input logic [2:0] sel, input int addr, input logic [15:0] w);
        int st;
        host_op(1'b1, sel, addr, w, "R1", st);
    endtask

    initial begin
        int st;
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        // R11: state while reset is held
        chk("R11 out_valid", 32'(out_valid), 0);
        chk("R11 loc_oe", 32'(loc_oe), 0);
        chk("R11 bp_oe", 32'(bp_oe), 0);
        chk("R11 loc_dout", 32'(loc_dout), 0);
        chk("R11 bp_dout", 32'(bp_dout), 0);
        chk("R11 host_rdata", 32'(host_rdata), 0);
        rst = 1'b0;
        step();

        // Fill both tables with random words (R1)
        for (int i = 0; i < NSLOT; i++) begin
            put(3'd0, i, 16'($urandom));
            put(3'd1, i, 16'($urandom));
        end
        // Directed corner words
        put(3'd0, 0, 16'h7F5A);  // message, driven, bits 12:8 set
        put(3'd0, 1, 16'hBABC);  // connection, local data, driven
        put(3'd0, 2, 16'h40A5);  // message, not driven
        put(3'd0, 3, 16'h0123);  // connection, not driven
        put(3'd0, 4, 16'h2FFF);  // connection, backplane data
        put(3'd1, 0, 16'hA07F);  // connection, backplane data
        put(3'd1, 1, 16'h3001);  // connection, local data
        put(3'd1, 2, 16'h7F3C);  // message, driven
        put(3'd1, 3, 16'h5F00);  // message, not driven
        put(3'd1, 4095, 16'h6011);

        // R1 readback from both tables
        for (int i = 0; i < 6; i++) begin
            host_op(1'b0, 3'd0, i * 700, 16'h0, "R1 local", st);
            host_op(1'b0, 3'd1, i * 700 + 1, 16'h0, "R1 backplane", st);
        end

        // R2 other codes: immediate, no effect, read as 0
        host_op(1'b1, 3'd2, 5, 16'hBEEF, "R2", st);
        chk("R2 no stall", st, 0);
        host_op(1'b1, 3'd7, 5, 16'hCAFE, "R2", st);
        host_op(1'b0, 3'd3, 5, 16'h0, "R2 bad code read", st);
        host_op(1'b0, 3'd0, 5, 16'h0, "R2 local untouched", st);
        host_op(1'b0, 3'd1, 5, 16'h0, "R2 backplane untouched", st);

        // R3/R4: back-to-back strobes over a full frame and its wrap
        tick_mode = 1;
        force_fp  = 1;
        repeat (NSLOT + 20) step();
        // R3: frame pulse in mid frame
        repeat (40) step();
        force_fp = 1;
        repeat (20) step();

        // R10: host held while strobes continue, bad code still free (R2)
        host_req = 1'b1; host_we = 1'b0; host_sel = 3'd0; host_addr = 12'd9;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R10 held during strobe", 32'(host_ready), 0);
            step();
        end
        host_sel = 3'd6;
        #1;
        chk("R2 free during strobe", 32'(host_ready), 1);
        host_req = 1'b0;
        step();

        // Random strobes, frame pulses and host traffic (R10 completion)
        tick_mode = 2;
        rand_fp   = 1;
        for (int i = 0; i < 2500; i++) begin
            step();
            if (($urandom % 8) == 0) begin
                int a;
                a = int'($urandom % NSLOT);
                host_op(1'b1, 3'($urandom % 3), a, 16'($urandom), "R10 write", st);
                host_op(1'b0, 3'($urandom % 2), a, 16'h0, "R10 read", st);
            end
        end

        tick_mode = 0;
        rand_fp   = 0;
        repeat (4) step();
        chk("R4 all strobes answered", q.size(), 0);
        finish_up();
    end

endmodule